// File: doc/BRIEF.md
# Gate driver fault supervisor

This block watches the protection flags of a three-phase gate driver and decides, each clock, which external switches may be driven. It receives the already-digitised condition flags: undervoltage on three supply rails, overvoltage on the gate supply, a temperature warning, a temperature shutdown, a temperature-cooled flag and one overcurrent flag for each high-side and low-side FET. It also receives the gate-enable pin, a one-cycle soft reset command from the register interface and a two-bit overcurrent policy. It passes the PWM requests through to the gate outputs only while the driver is allowed to run.

Each event class has its own response. Supply undervoltage blanks every output for as long as it lasts. Gate-supply overvoltage and temperature shutdown latch the driver and the charge pump off. The overcurrent response follows the selected policy: it can cut only the offending FET, latch the whole phase off, or only report the event. Two active-low outputs carry the reports. `fault_n` is low for any condition that stops switching, and stays low while the enable is off. `warn_n` is low for temperature and overcurrent events. A latched fault is cleared by holding the enable low for a long period. Short enable pulses and the soft reset do not clear the supply and temperature latches.

Top module: `gdfs_fault_sup`

## Requirements
- R1: While reset is held and right after it, every gate output and `cp_en` is 0, `status_clr` is 0, `fault_n` is 0 (the driver is not enabled) and `warn_n` is 1.
- R2: Every condition flag and `gate_en` passes through a two-flop synchronizer. A change of one of these inputs reaches the registered outputs on the third rising clock edge after it is applied. A PWM change reaches its gate output on the first edge.
- R3: `fault_n` and `cp_en` are 1 only while the synchronized enable is 1 and no shutdown is active. Each gate output then equals its PWM input, and `fault_n` = 1 always implies `cp_en` = 1.
- R4: Undervoltage on any rail (`uv_rail` bit 0 power stage, bit 1 logic, bit 2 gate supply) forces all gate outputs to 0 and drives `fault_n` low, leaves `warn_n` high and does not latch: outputs resume once the flag clears.
- R5: When the logic-rail undervoltage flag (`uv_rail` bit 1) clears, `status_clr` is high for exactly one cycle.
- R6: Gate-supply overvoltage latches all gate outputs and `cp_en` at 0 with `fault_n` low. Neither `soft_reset` nor an enable low period of up to LOW_MIN cycles releases the latch.
- R7: The temperature warning drives `warn_n` low and does not change the gate outputs or `fault_n`.
- R8: Temperature shutdown latches all gate outputs and `cp_en` at 0 and drives both report outputs low. The latch is released only by a long enable-low period during a cycle in which `ot_cool` is 1 and `ot_shut` is 0.
- R9: With `oc_mode` = 00 (current limit), an overcurrent turns off only the flagged FET and drives only `warn_n` low. After the flag clears, that FET resumes at the next rising edge of its own PWM input.
- R10: With `oc_mode` = 01 (latch), an overcurrent on either FET of a phase latches both gate outputs of that phase at 0 and drives both report outputs low. A long enable-low period or `soft_reset` releases it once the flag is gone.
- R11: With `oc_mode` = 10 or 11 (report only), an overcurrent drives `warn_n` low and leaves every gate output and `fault_n` unchanged.
- R12: A long enable-low period is one in which the synchronized `gate_en` has been 0 for more than LOW_MIN (default 16) consecutive cycles. A low input held for exactly LOW_MIN cycles is a quick toggle and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_rail | input | 3 | Undervoltage flags: bit 0 power stage, bit 1 logic, bit 2 gate supply |
| ov_gate | input | 1 | Gate-supply overvoltage flag |
| ot_warn | input | 1 | Temperature warning flag |
| ot_shut | input | 1 | Temperature shutdown flag |
| ot_cool | input | 1 | Temperature back below the release threshold |
| oc_hs | input | NPH | Overcurrent flag per high-side FET |
| oc_ls | input | NPH | Overcurrent flag per low-side FET |
| gate_en | input | 1 | Gate-enable pin |
| soft_reset | input | 1 | One-cycle soft reset command |
| oc_mode | input | 2 | Overcurrent policy: 00 limit, 01 latch, 10/11 report |
| pwm_hs | input | NPH | High-side PWM requests |
| pwm_ls | input | NPH | Low-side PWM requests |
| gate_hs | output | NPH | High-side gate enables |
| gate_ls | output | NPH | Low-side gate enables |
| cp_en | output | 1 | Charge-pump enable |
| status_clr | output | 1 | One-cycle clear of the status registers |
| fault_n | output | 1 | Active-low shutdown report |
| warn_n | output | 1 | Active-low warning report |

## Verification
The hardest state to reach from the ports is the boundary of the enable-low filter while a latch is set. A quick toggle must leave the latch in place, and a low period only one cycle longer must release it. The temperature latch adds a further condition: the release also depends on the cooled flag during the long low period. The stimulus latches the overvoltage fault and then drops `gate_en` for exactly LOW_MIN cycles and then for LOW_MIN+1 cycles. It then repeats the long low period with `ot_cool` off and then on. A behavioural model running beside the design predicts every output on every cycle, so the cycle on which the release happens is checked exactly.

// File: rtl/gdfs_pkg.sv
package gdfs_pkg;

    // overcurrent policy selected by the two-bit mode input
    typedef enum logic [1:0] {
        OCM_LIMIT   = 2'b00,
        OCM_LATCH   = 2'b01,
        OCM_REPORT  = 2'b10,
        OCM_REPORT2 = 2'b11
    } oc_mode_e;

    // supply rail index for undervoltage flags
    localparam int RAIL_POWER = 0;
    localparam int RAIL_LOGIC = 1;
    localparam int RAIL_GATE  = 2;
    localparam int NUM_RAILS  = 3;

endpackage

// File: rtl/gdfs_sync.sv
module gdfs_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = din;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign dout = stab_q;

endmodule

// File: rtl/gdfs_en_filter.sv
module gdfs_en_filter #(
    parameter int LOW_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    output logic long_low
);

    localparam int CW = $clog2(LOW_MIN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(LOW_MIN);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (en_s)
            cnt_d = '0;
        else if (cnt_q != CNT_TOP)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
        // true on every low cycle after LOW_MIN earlier low cycles
        long_low = !en_s && (cnt_q == CNT_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/gdfs_phase_ctl.sv
module gdfs_phase_ctl
    import gdfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       oc_h,
    input  logic       oc_l,
    input  logic       pwm_h,
    input  logic       pwm_l,
    input  logic       soft_reset,
    input  logic       long_low,
    input  logic       drive_ok,
    output logic       lat_d,
    output logic       lat_q,
    output logic       gate_h,
    output logic       gate_l
);

    // index 0 high side, index 1 low side
    typedef struct packed {
        logic       lat;
        logic [1:0] cl_off;
        logic [1:0] pwm_prev;
        logic [1:0] gate;
    } ph_st_t;

    localparam ph_st_t PH_RST = '{lat: 1'b0, cl_off: 2'b00, pwm_prev: 2'b00, gate: 2'b00};

    ph_st_t   q, d;
    oc_mode_e m;
    logic     is_limit, is_latch;
    logic [1:0] oc_v, pwm_v;

    assign m        = oc_mode_e'(mode);
    assign is_limit = (m == OCM_LIMIT);
    assign is_latch = (m == OCM_LATCH);
    assign oc_v     = {oc_l, oc_h};
    assign pwm_v    = {pwm_l, pwm_h};

    always_comb begin
        d = q;
        d.lat = (is_latch && (oc_h || oc_l)) ||
                (q.lat && !(soft_reset || long_low));
        for (int s = 0; s < 2; s++) begin
            d.cl_off[s]   = is_limit &&
                            (oc_v[s] || (q.cl_off[s] && !(pwm_v[s] && !q.pwm_prev[s])));
            d.pwm_prev[s] = pwm_v[s];
            d.gate[s]     = drive_ok && !d.lat && !d.cl_off[s] && pwm_v[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= PH_RST;
        else        q <= d;
    end

    assign lat_d  = d.lat;
    assign lat_q  = q.lat;
    assign gate_h = q.gate[0];
    assign gate_l = q.gate[1];

endmodule

// File: rtl/gdfs_fault_sup.sv
module gdfs_fault_sup
    import gdfs_pkg::*;
#(
    parameter int NPH     = 3,
    parameter int LOW_MIN = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     uv_rail,
    input  logic           ov_gate,
    input  logic           ot_warn,
    input  logic           ot_shut,
    input  logic           ot_cool,
    input  logic [NPH-1:0] oc_hs,
    input  logic [NPH-1:0] oc_ls,
    input  logic           gate_en,
    input  logic           soft_reset,
    input  logic [1:0]     oc_mode,
    input  logic [NPH-1:0] pwm_hs,
    input  logic [NPH-1:0] pwm_ls,
    output logic [NPH-1:0] gate_hs,
    output logic [NPH-1:0] gate_ls,
    output logic           cp_en,
    output logic           status_clr,
    output logic           fault_n,
    output logic           warn_n
);

    localparam int SW = NUM_RAILS + 5 + 2 * NPH;

    typedef struct packed {
        logic ov_lat;
        logic ot_lat;
        logic dv_prev;
        logic status_clr;
        logic cp_en;
        logic fault_n;
        logic warn_n;
    } top_st_t;

    localparam top_st_t TOP_RST = '{ov_lat: 1'b0, ot_lat: 1'b0, dv_prev: 1'b0,
                                     status_clr: 1'b0, cp_en: 1'b0,
                                     fault_n: 1'b0, warn_n: 1'b1};

    logic [SW-1:0]  raw_v, syn_v;
    logic [2:0]     uv_s;
    logic           ov_s, otw_s, ots_s, otc_s, en_s;
    logic [NPH-1:0] oc_hs_s, oc_ls_s;
    logic           long_low;
    logic           drive_ok;
    logic [NPH-1:0] oc_lat_d, oc_lat_q;
    logic           ov_lat_q, ot_lat_q;
    top_st_t        q, d;

    assign raw_v = {uv_rail, ov_gate, ot_warn, ot_shut, ot_cool, gate_en, oc_hs, oc_ls};

    gdfs_sync #(.WIDTH(SW)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_v),
        .dout (syn_v)
    );

    assign {uv_s, ov_s, otw_s, ots_s, otc_s, en_s, oc_hs_s, oc_ls_s} = syn_v;

    gdfs_en_filter #(.LOW_MIN(LOW_MIN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (en_s),
        .long_low(long_low)
    );

    always_comb begin
        d = q;
        d.ov_lat     = ov_s || (q.ov_lat && !long_low);
        d.ot_lat     = ots_s || (q.ot_lat && !(long_low && otc_s));
        d.dv_prev    = uv_s[RAIL_LOGIC];
        d.status_clr = q.dv_prev && !uv_s[RAIL_LOGIC];
        drive_ok     = en_s && !(|uv_s) && !d.ov_lat && !d.ot_lat;
        d.cp_en      = en_s && !d.ov_lat && !d.ot_lat;
        d.fault_n    = drive_ok && !(|oc_lat_d);
        d.warn_n     = !(otw_s || ots_s || d.ot_lat ||
                         (|oc_hs_s) || (|oc_ls_s) || (|oc_lat_d));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TOP_RST;
        else        q <= d;
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        gdfs_phase_ctl u_ph (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (oc_mode),
            .oc_h      (oc_hs_s[p]),
            .oc_l      (oc_ls_s[p]),
            .pwm_h     (pwm_hs[p]),
            .pwm_l     (pwm_ls[p]),
            .soft_reset(soft_reset),
            .long_low  (long_low),
            .drive_ok  (drive_ok),
            .lat_d     (oc_lat_d[p]),
            .lat_q     (oc_lat_q[p]),
            .gate_h    (gate_hs[p]),
            .gate_l    (gate_ls[p])
        );
    end

    assign ov_lat_q   = q.ov_lat;
    assign ot_lat_q   = q.ot_lat;
    assign cp_en      = q.cp_en;
    assign status_clr = q.status_clr;
    assign fault_n    = q.fault_n;
    assign warn_n     = q.warn_n;

endmodule

// File: rtl/gdfs_fault_sup_chk.sv
module gdfs_fault_sup_chk #(
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2:0]     uv_s,
    input logic           otw_s,
    input logic           otc_s,
    input logic           long_low,
    input logic           ov_lat_q,
    input logic           ot_lat_q,
    input logic [NPH-1:0] oc_lat_q,
    input logic [NPH-1:0] gate_hs,
    input logic [NPH-1:0] gate_ls,
    input logic           cp_en,
    input logic           status_clr,
    input logic           fault_n,
    input logic           warn_n
);

    p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n |-> cp_en);

    p_uv_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|uv_s) |=> (gate_hs == '0 && gate_ls == '0 && !fault_n));

    p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uv_s[1]) |=> status_clr);

    p_ov_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_lat_q && !long_low) |=> ov_lat_q);

    p_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        otw_s |=> !warn_n);

    p_ot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_lat_q && !(long_low && otc_s)) |=> ot_lat_q);

    p_pump_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_en |-> (gate_hs == '0 && gate_ls == '0));

    p_phase_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_lat_q & (gate_hs | gate_ls)) == '0);

endmodule

bind gdfs_fault_sup gdfs_fault_sup_chk #(.NPH(NPH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_s      (uv_s),
    .otw_s     (otw_s),
    .otc_s     (otc_s),
    .long_low  (long_low),
    .ov_lat_q  (ov_lat_q),
    .ot_lat_q  (ot_lat_q),
    .oc_lat_q  (oc_lat_q),
    .gate_hs   (gate_hs),
    .gate_ls   (gate_ls),
    .cp_en     (cp_en),
    .status_clr(status_clr),
    .fault_n   (fault_n),
    .warn_n    (warn_n)
);

// File: tb/tb_gdfs_fault_sup.sv
module tb_gdfs_fault_sup;

    localparam int NPH = 3;
    localparam int LOW_MIN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] uv_rail = '0;
    logic ov_gate = 0, ot_warn = 0, ot_shut = 0, ot_cool = 0;
    logic [NPH-1:0] oc_hs = '0, oc_ls = '0;
    logic gate_en = 0, soft_reset = 0;
    logic [1:0] oc_mode = 2'b00;
    logic [NPH-1:0] pwm_hs = '0, pwm_ls = '0;
    logic [NPH-1:0] gate_hs, gate_ls;
    logic cp_en, status_clr, fault_n, warn_n;

    always #2 clk = ~clk;

    gdfs_fault_sup #(.NPH(NPH), .LOW_MIN(LOW_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .uv_rail(uv_rail), .ov_gate(ov_gate),
        .ot_warn(ot_warn), .ot_shut(ot_shut), .ot_cool(ot_cool),
        .oc_hs(oc_hs), .oc_ls(oc_ls), .gate_en(gate_en), .soft_reset(soft_reset),
        .oc_mode(oc_mode), .pwm_hs(pwm_hs), .pwm_ls(pwm_ls),
        .gate_hs(gate_hs), .gate_ls(gate_ls), .cp_en(cp_en),
        .status_clr(status_clr), .fault_n(fault_n), .warn_n(warn_n)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic [2:0] uv;
        logic ov, otw, ots, otc, en;
        logic [NPH-1:0] ohs, ols;
    } snap_t;

    snap_t dly[$];
    int  low_cnt;
    bit  m_ov, m_ot, m_dvp;
    bit  m_lat[NPH];
    bit  m_offh[NPH], m_offl[NPH], m_ph[NPH], m_pl[NPH];
    logic [NPH-1:0] e_hs, e_ls;
    bit  e_cp, e_clr, e_flt, e_wrn;

    task automatic model_reset();
        dly.delete();
        dly.push_back('0);
        dly.push_back('0);
        low_cnt = 0;
        m_ov = 0; m_ot = 0; m_dvp = 0;
        for (int p = 0; p < NPH; p++) begin
            m_lat[p] = 0; m_offh[p] = 0; m_offl[p] = 0; m_ph[p] = 0; m_pl[p] = 0;
        end
        e_hs = '0; e_ls = '0; e_cp = 0; e_clr = 0; e_flt = 0; e_wrn = 1;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            snap_t c;
            bit ll, uvany, anyoc, anylat, run;
            c = dly.pop_front();
            dly.push_back({uv_rail, ov_gate, ot_warn, ot_shut, ot_cool, gate_en, oc_hs, oc_ls});
            ll = !c.en && (low_cnt >= LOW_MIN);
            if (c.en) low_cnt = 0;
            else if (low_cnt < LOW_MIN) low_cnt++;
            if (c.ov) m_ov = 1; else if (ll) m_ov = 0;
            if (c.ots) m_ot = 1; else if (ll && c.otc) m_ot = 0;
            e_clr = m_dvp && !c.uv[1];
            m_dvp = c.uv[1];
            uvany = (c.uv != 0);
            anyoc = (c.ohs != 0) || (c.ols != 0);
            anylat = 0;
            run = c.en && !uvany && !m_ov && !m_ot;
            for (int p = 0; p < NPH; p++) begin
                if (oc_mode == 2'b01 && (c.ohs[p] || c.ols[p])) m_lat[p] = 1;
                else if (soft_reset || ll) m_lat[p] = 0;
                if (oc_mode != 2'b00) m_offh[p] = 0;
                else if (c.ohs[p]) m_offh[p] = 1;
                else if (pwm_hs[p] && !m_ph[p]) m_offh[p] = 0;
                if (oc_mode != 2'b00) m_offl[p] = 0;
                else if (c.ols[p]) m_offl[p] = 1;
                else if (pwm_ls[p] && !m_pl[p]) m_offl[p] = 0;
                m_ph[p] = pwm_hs[p];
                m_pl[p] = pwm_ls[p];
                if (m_lat[p]) anylat = 1;
                e_hs[p] = run && !m_lat[p] && !m_offh[p] && pwm_hs[p];
                e_ls[p] = run && !m_lat[p] && !m_offl[p] && pwm_ls[p];
            end
            e_cp  = c.en && !m_ov && !m_ot;
            e_flt = run && !anylat;
            e_wrn = !(c.otw || c.ots || m_ot || anyoc || anylat);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        checks++;
        if ({gate_hs, gate_ls, cp_en, status_clr, fault_n, warn_n} !==
            {e_hs, e_ls, e_cp, e_clr, e_flt, e_wrn}) begin
            errors++;
            $display("FAIL %s model: got hs=%b ls=%b cp=%b clr=%b flt=%b wrn=%b exp hs=%b ls=%b cp=%b clr=%b flt=%b wrn=%b",
                     cur_req, gate_hs, gate_ls, cp_en, status_clr, fault_n, warn_n,
                     e_hs, e_ls, e_cp, e_clr, e_flt, e_wrn);
        end
    end

    int clr_pulses = 0;
    always @(negedge clk) if (rst_n && status_clr) clr_pulses++;

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic long_low_pulse(int n);
        gate_en = 0;
        step(n);
        gate_en = 1;
        step(6);
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        step(3);
        chk("R1 reset", {gate_hs, gate_ls, cp_en, status_clr, fault_n, warn_n}, {6'b0, 4'b0001});
        rst_n = 1;
        step(4);
        chk("R1 after reset", {gate_hs, gate_ls, cp_en, fault_n, warn_n}, {6'b0, 3'b001});

        // R3 startup, gates follow pwm
        cur_req = "R3";
        pwm_hs = 3'b101; pwm_ls = 3'b010;
        gate_en = 1;
        step(6);
        chk("R3 ready", {cp_en, fault_n}, 2'b11);
        chk("R3 follow", {gate_hs, gate_ls}, {3'b101, 3'b010});
        pwm_hs = 3'b010; pwm_ls = 3'b101;
        step(1);
        chk("R2 pwm one edge", {gate_hs, gate_ls}, {3'b010, 3'b101});

        // R2 synchronizer latency of three edges
        cur_req = "R2";
        ot_warn = 1;
        step(2);
        chk("R2 two edges", warn_n, 1);
        step(1);
        chk("R2 three edges", warn_n, 0);
        // R7 warning only
        cur_req = "R7";
        step(2);
        chk("R7 warn", {fault_n, cp_en, gate_hs}, {2'b11, 3'b010});
        ot_warn = 0;
        step(5);
        chk("R7 released", warn_n, 1);

        // R4 undervoltage on rails 0 and 2
        cur_req = "R4";
        for (int r = 0; r < 3; r += 2) begin
            uv_rail = 3'(1 << r);
            step(5);
            chk("R4 off", {gate_hs, gate_ls, fault_n, warn_n}, {6'b0, 2'b01});
            uv_rail = '0;
            step(5);
            chk("R4 recover", {fault_n, gate_hs}, {1'b1, 3'b010});
        end

        // R5 logic-rail undervoltage recovery pulse
        cur_req = "R5";
        clr_pulses = 0;
        uv_rail = 3'b010;
        step(6);
        chk("R5 no pulse during", clr_pulses, 0);
        uv_rail = '0;
        step(8);
        chk("R5 one pulse", clr_pulses, 1);

        // R6 overvoltage latch, soft reset and quick toggle ignored; R12 boundary
        cur_req = "R6";
        ov_gate = 1;
        step(4);
        ov_gate = 0;
        step(4);
        chk("R6 latched", {gate_hs, gate_ls, cp_en, fault_n}, {6'b0, 2'b00});
        soft_reset = 1; step(1); soft_reset = 0;
        step(3);
        chk("R6 soft reset ignored", {cp_en, fault_n}, 2'b00);
        cur_req = "R12";
        long_low_pulse(5);
        chk("R6 quick toggle ignored", {cp_en, fault_n}, 2'b00);
        long_low_pulse(LOW_MIN);
        chk("R12 exactly LOW_MIN", {cp_en, fault_n}, 2'b00);
        long_low_pulse(LOW_MIN + 1);
        chk("R12 LOW_MIN+1 clears", {cp_en, fault_n}, 2'b11);

        // R8 temperature shutdown latch
        cur_req = "R8";
        ot_shut = 1;
        step(4);
        ot_shut = 0;
        step(4);
        chk("R8 latched", {gate_hs, cp_en, fault_n, warn_n}, {3'b0, 3'b000});
        long_low_pulse(LOW_MIN + 4);
        chk("R8 not cool", {cp_en, fault_n}, 2'b00);
        ot_cool = 1;
        long_low_pulse(LOW_MIN + 4);
        chk("R8 cleared", {cp_en, fault_n, warn_n}, 3'b111);
        ot_cool = 0;

        // R9 current limit mode
        cur_req = "R9";
        oc_mode = 2'b00;
        pwm_hs = 3'b111; pwm_ls = 3'b000;
        step(2);
        oc_hs = 3'b010;
        step(5);
        chk("R9 only flagged off", {gate_hs, fault_n, warn_n}, {3'b101, 2'b10});
        oc_hs = '0;
        step(6);
        chk("R9 waits for pwm edge", gate_hs, 3'b101);
        pwm_hs = 3'b101; step(2);
        pwm_hs = 3'b111; step(1);
        chk("R9 resumed on edge", gate_hs, 3'b111);

        // R10 latch mode
        cur_req = "R10";
        oc_mode = 2'b01;
        pwm_ls = 3'b100; pwm_hs = 3'b111;
        step(2);
        oc_ls = 3'b100;
        step(5);
        oc_ls = '0;
        step(5);
        chk("R10 phase off", {gate_hs, gate_ls, fault_n, warn_n}, {3'b011, 3'b000, 2'b00});
        soft_reset = 1; step(1); soft_reset = 0;
        step(2);
        chk("R10 soft reset clears", {gate_hs, gate_ls, fault_n, warn_n}, {3'b111, 3'b100, 2'b11});

        // R11 report only, both codes
        cur_req = "R11";
        for (int md = 2; md < 4; md++) begin
            oc_mode = 2'(md);
            step(1);
            oc_hs = 3'b001; oc_ls = 3'b100;
            step(5);
            chk("R11 report only", {gate_hs, gate_ls, fault_n, warn_n}, {3'b111, 3'b100, 2'b10});
            oc_hs = '0; oc_ls = '0;
            step(5);
            chk("R11 released", warn_n, 1);
        end

        step(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule